// File: doc/BRIEF.md
# Modem Status Change Register

This block holds the modem status byte of a UART and produces that UART's modem-status interrupt request. It takes the four active-low modem inputs, which are clear-to-send, data-set-ready, ring indicator and carrier detect. It resynchronizes them to the block clock and shows their present conditions in the upper nibble of the status byte. The lower nibble holds sticky change flags. Reading the byte through a one-cycle read strobe clears the flags. The interrupt request is raised while any flag is set and the interrupt is enabled. A CTS change is left out of the request while automatic CTS flow control is on, because the transmitter handles that line itself.

The ring indicator flag works differently from the other three. It catches only the end of a ring, which is the pin returning high. The other three flags catch a change in either direction. In loopback mode the four conditions come from the modem control output bits instead of the pins. This lets software exercise the whole status path without a cable.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, with all four pins high (inactive), the status byte reads 0x00 and the interrupt request is low.
- R2: Status bits 4, 5, 6 and 7 show the conditions of CTS, DSR, RI and DCD. A condition is 1 when its pin is low. A pin change appears on the status byte on the third rising clock edge after it, and not before.
- R3: Bits 0 (CTS), 1 (DSR) and 3 (DCD) are set on the same edge that the matching condition bit changes, whichever direction the change goes.
- R4: Bit 2 is set only when the RI condition goes from 1 to 0, which is the pin rising. The RI condition going from 0 to 1 does not set it.
- R5: A change flag stays set until a read. When the read strobe is high, the byte seen in that cycle still holds the flags, and the flags are clear after that clock edge.
- R6: If a change is detected on the same edge as a read, its flag is set after the read. Flags that were set before the read are cleared.
- R7: The interrupt request is high exactly when the interrupt enable is high and at least one counted flag is set. With the enable low, the request stays low while the flags still read back.
- R8: While automatic CTS control is on, bit 0 is not counted for the interrupt request, but it is still set and read back. The request follows bit 0 again as soon as that control is turned off.
- R9: In loopback mode, bits 4 to 7 take the values of the request-to-send, terminal-ready, output-1 and output-2 control bits one clock edge later. Pin activity changes no status bit in this mode.
- R10: The interrupt request drops after the edge that ends a read, and it drops during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsrN | input | 1 | Data-set-ready pin, active low, asynchronous |
| riN | input | 1 | Ring indicator pin, active low, asynchronous |
| dcdN | input | 1 | Carrier detect pin, active low, asynchronous |
| loopEn | input | 1 | Loopback mode: take conditions from the control bits |
| loopRts | input | 1 | Request-to-send control bit, looped onto CTS |
| loopDtr | input | 1 | Terminal-ready control bit, looped onto DSR |
| loopOut1 | input | 1 | Output-1 control bit, looped onto RI |
| loopOut2 | input | 1 | Output-2 control bit, looped onto DCD |
| autoCtsEn | input | 1 | Automatic CTS flow control is active |
| msIntEn | input | 1 | Modem-status interrupt enable |
| rdStb | input | 1 | One-cycle read of the status byte |
| statusOut | output | 8 | Status byte: [7:4] conditions, [3:0] change flags |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
The pins are driven both singly and in pairs, and in both directions. A single CTS assertion sampled one edge early and then on time pins down the synchronizer latency. Releasing DSR shows that the plain flags respond to both directions. RI is asserted and then released, which shows that only its trailing edge counts. A CTS change is placed exactly on the read edge to tell "kept" apart from "lost". The automatic CTS mask is turned off while the CTS flag is still set. Loopback is tried with the pins toggling underneath, which shows that the pins are ignored and the control bits are used instead.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NUM_LINES = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_LINES-1:0] setFlag;
    logic                 clrFlags;
  } msrStrobes_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinN,
  input  logic                 loopEn,
  input  logic [NUM_LINES-1:0] loopBits,
  input  msrStrobes_t          strb,
  output logic [NUM_LINES-1:0] rawCond,
  output logic [NUM_LINES-1:0] curCond,
  output logic [NUM_LINES-1:0] flags
);
  logic [NUM_LINES-1:0] pinSync;

  msr_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (NUM_LINES),
    .RESET_VAL({NUM_LINES{1'b1}})
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (pinN),
    .dout(pinSync)
  );

  // condition source: control bits in loopback, inverted pins otherwise
  assign rawCond = loopEn ? loopBits : ~pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCond <= '0;
      flags   <= '0;
    end else begin
      curCond <= rawCond;
      // a new set wins over a clear on the same edge
      flags   <= (flags & ~{NUM_LINES{strb.clrFlags}}) | strb.setFlag;
    end
  end
endmodule

// File: rtl/msr_control.sv
module msr_control
  import msr_pkg::*;
(
  input  logic [NUM_LINES-1:0] rawCond,
  input  logic [NUM_LINES-1:0] curCond,
  input  logic [NUM_LINES-1:0] flags,
  input  logic                 rdStb,
  input  logic                 msIntEn,
  input  logic                 autoCtsEn,
  output msrStrobes_t          strb,
  output logic                 irq
);
  logic [NUM_LINES-1:0] setVec;
  logic [NUM_LINES-1:0] irqMask;

  for (genvar i = 0; i < NUM_LINES; i++) begin : gEdge
    if (i == IDX_RI) begin : gTrail
      // condition dropping means the pin went high
      assign setVec[i] = curCond[i] & ~rawCond[i];
    end else begin : gAny
      assign setVec[i] = curCond[i] ^ rawCond[i];
    end
    if (i == IDX_CTS) begin : gCtsMask
      assign irqMask[i] = ~autoCtsEn;
    end else begin : gNoMask
      assign irqMask[i] = 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.setFlag  = setVec;
    strb.clrFlags = rdStb;
  end

  assign irq = msIntEn & (|(flags & irqMask));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       loopEn,
  input  logic       loopRts,
  input  logic       loopDtr,
  input  logic       loopOut1,
  input  logic       loopOut2,
  input  logic       autoCtsEn,
  input  logic       msIntEn,
  input  logic       rdStb,
  output logic [7:0] statusOut,
  output logic       msIrq
);
  logic [NUM_LINES-1:0] pinN;
  logic [NUM_LINES-1:0] loopBits;
  logic [NUM_LINES-1:0] rawCond;
  logic [NUM_LINES-1:0] curCond;
  logic [NUM_LINES-1:0] flags;
  msrStrobes_t          strb;

  assign pinN     = {dcdN, riN, dsrN, ctsN};
  assign loopBits = {loopOut2, loopOut1, loopDtr, loopRts};

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pinN    (pinN),
    .loopEn  (loopEn),
    .loopBits(loopBits),
    .strb    (strb),
    .rawCond (rawCond),
    .curCond (curCond),
    .flags   (flags)
  );

  msr_control uCtl (
    .rawCond  (rawCond),
    .curCond  (curCond),
    .flags    (flags),
    .rdStb    (rdStb),
    .msIntEn  (msIntEn),
    .autoCtsEn(autoCtsEn),
    .strb     (strb),
    .irq      (msIrq)
  );

  assign statusOut = {curCond, flags};
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdStb,
  input logic       msIntEn,
  input logic       autoCtsEn,
  input logic       loopEn,
  input logic       loopRts,
  input logic       loopDtr,
  input logic       loopOut1,
  input logic       loopOut2,
  input logic [7:0] statusOut,
  input logic       msIrq
);
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> ((statusOut[3:0] & $past(statusOut[3:0])) == $past(statusOut[3:0]))); // R5
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb ##1 $stable(statusOut[7:4])) |-> (statusOut[3:0] == 4'b0000)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    msIrq |-> msIntEn); // R7
  AST_IRQ_CTS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && statusOut[3:1] == 3'b000) |-> !msIrq); // R8
  AST_RI_TRAILING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[2]) |-> $fell(statusOut[6])); // R4
  AST_CTS_DELTA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[0]) |-> (statusOut[4] != $past(statusOut[4]))); // R3
  AST_LOOP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> (statusOut[7:4] == {$past(loopOut2), $past(loopOut1), $past(loopDtr), $past(loopRts)})); // R9
endmodule

bind modem_status_reg msr_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStb    (rdStb),
  .msIntEn  (msIntEn),
  .autoCtsEn(autoCtsEn),
  .loopEn   (loopEn),
  .loopRts  (loopRts),
  .loopDtr  (loopDtr),
  .loopOut1 (loopOut1),
  .loopOut2 (loopOut2),
  .statusOut(statusOut),
  .msIrq    (msIrq)
);

// File: tb/sim_modem_status_reg.sv
`timescale 1ns/1ps
module sim_modem_status_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic loopEn = 1'b0, loopRts = 1'b0, loopDtr = 1'b0, loopOut1 = 1'b0, loopOut2 = 1'b0;
  logic autoCtsEn = 1'b0, msIntEn = 1'b0, rdStb = 1'b0;
  logic [7:0] statusOut;
  logic msIrq;
  int nTests = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  modem_status_reg u0 (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .loopEn(loopEn), .loopRts(loopRts), .loopDtr(loopDtr), .loopOut1(loopOut1),
    .loopOut2(loopOut2), .autoCtsEn(autoCtsEn), .msIntEn(msIntEn), .rdStb(rdStb),
    .statusOut(statusOut), .msIrq(msIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  // read: returns the byte seen during the strobe cycle
  task automatic doRead(output logic [7:0] seen);
    rdStb = 1'b1;
    #1 seen = statusOut;
    tick(1);
    rdStb = 1'b0;
  endtask

  task automatic tReset();
    chk("R1", "status after reset", statusOut, 8'h00);
    chk("R1", "irq after reset", {7'b0, msIrq}, 8'h00);
  endtask

  task automatic tCtsLevel();
    logic [7:0] seen;
    ctsN = 1'b0;
    tick(2);
    chk("R2", "cts not yet visible", statusOut, 8'h00);
    tick(1);
    chk("R2", "cts level and delta", statusOut, 8'h11);
    chk("R7", "irq with enable low", {7'b0, msIrq}, 8'h00);
    doRead(seen);
    chk("R5", "byte seen during read", seen, 8'h11);
    chk("R5", "flags cleared after read", statusOut, 8'h10);
  endtask

  task automatic tDsrDcd();
    logic [7:0] seen;
    dsrN = 1'b0; dcdN = 1'b0;
    tick(3);
    chk("R3", "dsr and dcd assert", statusOut, 8'hBA);
    msIntEn = 1'b1;
    #1 chk("R7", "irq with enable", {7'b0, msIrq}, 8'h01);
    doRead(seen);
    chk("R10", "irq cleared by read", {7'b0, msIrq}, 8'h00);
    dsrN = 1'b1;
    tick(3);
    chk("R3", "dsr release sets delta", statusOut, 8'h92);
    doRead(seen);
  endtask

  task automatic tRing();
    logic [7:0] seen;
    riN = 1'b0;
    tick(3);
    chk("R4", "ri start does not flag", statusOut, 8'hD0);
    riN = 1'b1;
    tick(3);
    chk("R4", "ri end flags", statusOut, 8'h94);
    doRead(seen);
  endtask

  task automatic tAutoCts();
    logic [7:0] seen;
    autoCtsEn = 1'b1;
    ctsN = 1'b1;
    tick(3);
    chk("R8", "cts flag still set", statusOut, 8'h81);
    chk("R8", "cts masked from irq", {7'b0, msIrq}, 8'h00);
    autoCtsEn = 1'b0;
    #1 chk("R8", "irq after mask off", {7'b0, msIrq}, 8'h01);
    doRead(seen);
  endtask

  task automatic tSameCycle();
    logic [7:0] seen;
    dcdN = 1'b1;
    tick(3);
    chk("R3", "dcd release delta", statusOut, 8'h08);
    ctsN = 1'b0;
    tick(2);
    doRead(seen);
    chk("R6", "byte seen on colliding read", seen, 8'h08);
    chk("R6", "new cts delta kept", statusOut, 8'h11);
    ctsN = 1'b1;
    tick(3);
    doRead(seen);
    chk("R5", "quiet state", statusOut, 8'h00);
  endtask

  task automatic tLoop();
    logic [7:0] seen;
    loopEn = 1'b1;
    tick(1);
    chk("R9", "loop entry quiet", statusOut, 8'h00);
    ctsN = 1'b0; dsrN = 1'b0; riN = 1'b0;
    tick(3);
    chk("R9", "pins ignored in loop", statusOut, 8'h00);
    loopRts = 1'b1; loopOut2 = 1'b1;
    tick(1);
    chk("R9", "rts and out2 looped", statusOut, 8'h99);
    chk("R9", "irq from looped change", {7'b0, msIrq}, 8'h01);
    doRead(seen);
    loopOut1 = 1'b1;
    tick(1);
    chk("R4", "looped ri start no flag", statusOut, 8'hD0);
    loopOut1 = 1'b0;
    tick(1);
    chk("R4", "looped ri end flags", statusOut, 8'h94);
    rstN = 1'b0;
    #1 chk("R10", "irq dropped in reset", {7'b0, msIrq}, 8'h00);
    chk("R1", "flags cleared in reset", {4'b0, statusOut[3:0]}, 8'h00);
    tick(1);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    tReset();
    tCtsLevel();
    tDsrDcd();
    tRing();
    tAutoCts();
    tSameCycle();
    tLoop();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule